// File: doc/BRIEF.md
# Host Clock Divider with Stretched Reset

This block derives a slower clock for an attached host processor from the oscillator clock and turns a raw external reset into a clean internal one. A small configuration register selects the division factor, can silence the output, and carries a static comparator-bypass control that is exported to the receive input path. Division factors are 1 and the even values 2 to 14. Even factors give a square wave with equal high and low phases, and factor 1 passes the oscillator clock straight through.

The divider is a four-state machine. `ST_IDLE` holds the output low. `ST_HIGH` and `ST_LOW` time the two half periods of a divided clock. `ST_PASS` forwards the oscillator clock. The transitions are:
- IDLE→HIGH (enabled, even factor)
- IDLE→PASS (enabled, factor 1)
- HIGH→LOW (high phase done)
- LOW→HIGH (period boundary, even factor)
- LOW→PASS (boundary, factor 1)
- LOW→IDLE (boundary, output switched off)
- PASS→HIGH (factor changed away from 1, or switched off; when switched off, the high phase lasts one cycle and is followed by one low cycle)

A new factor or the off request is sampled only at the end of a low phase, so every phase the output produces has full length.

The external reset clears a two-stage synchronizer at once. After the reset is released, a counter holds the internal reset for a further 15 oscillator cycles. The default factor loaded by reset depends on a bus-style strap pin.

Top module: `host_clock_divider`

## Requirements
- R1: Field code c in cfg bits [2:0], for c from 0 to 6, divides by 2·(c+1): the output is high for c+1 oscillator cycles, then low for c+1 cycles.
- R2: Code 7 in bits [2:0] forwards the oscillator clock unchanged to `clk_out`.
- R3: Reset loads the register with the off bit and the bypass bit cleared. The code loaded is 0 (divide by 2) when `mode_sel` is high and 5 (divide by 12) when `mode_sel` is low.
- R4: Setting bit 3 (off) lets the current high phase finish and then holds `clk_out` low from the next low phase onward.
- R5: A new code takes effect only where the divided output rises. Every complete phase seen after a write has the old half-period or the new one, and once the new length appears the old length does not return.
- R6: Bit 7 drives `cmp_bypass` as a static level that changes only on a register write.
- R7: `cfg_rdata` returns {bit7 bypass, 3'b000, bit3 off, bits[2:0] code}. Writes to bits 6:4 are ignored.
- R8: `rst_sync_n` falls as soon as `rst_ext_n` goes low. After `rst_ext_n` is released, `rst_sync_n` rises at the 17th rising oscillator edge: 2 synchronizer stages plus 15 stretch cycles.
- R9: While `rst_sync_n` is low, `clk_out` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| rst_ext_n | input | 1 | External reset, active low, asynchronous |
| mode_sel | input | 1 | Bus-style strap; selects the default factor at reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read-back |
| clk_out | output | 1 | Divided or forwarded clock for the host |
| cmp_bypass | output | 1 | Static comparator-bypass select |
| rst_sync_n | output | 1 | Synchronized, stretched internal reset, active low |

## Verification
The assertions assume that `mode_sel` is static outside reset, that `cfg_we` is raised only after `rst_sync_n` has risen, and that `rst_ext_n` changes away from the rising oscillator edge. The bench drives every input at the falling edge and writes the register only after the stretched reset has completed. It changes the strap only while reset is held. The random transitions start from a settled even factor and move either to another even factor or to the off state, so that the run-length checks apply.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] PASS_CODE   = 3'd7;
    localparam logic [CODE_W-1:0] DEF_STROBE  = 3'd0;  // divide by 2
    localparam logic [CODE_W-1:0] DEF_ENABLE  = 3'd5;  // divide by 12

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_PASS
    } div_state_e;

    // half period in oscillator cycles for an even-divide code
    function automatic logic [CODE_W-1:0] half_of(input logic [CODE_W-1:0] code);
        return code + 1'b1;
    endfunction

endpackage

// File: rtl/rst_stretch.sv
module rst_stretch #(
    parameter int SYNC_STAGES = 2,
    parameter int STRETCH     = 15
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    localparam int CW = $clog2(STRETCH + 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(STRETCH);
    localparam logic [CW-1:0] CNT_LAST = CW'(STRETCH - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic [CW-1:0]          cnt_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) sync_q <= '0;
                else         sync_q <= 1'b1;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) sync_q <= '0;
                else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q   <= '0;
            rst_n_o <= 1'b0;
        end else begin
            if (!synced)              cnt_q <= '0;
            else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
            rst_n_o <= synced && (cnt_q >= CNT_LAST);
        end
    end
endmodule

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
    import clkdiv_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OFF_BIT = 3,
    parameter int BYP_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CODE_W-1:0] code,
    output logic              off,
    output logic              bypass
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code   <= mode_sel ? DEF_STROBE : DEF_ENABLE;
            off    <= 1'b0;
            bypass <= 1'b0;
        end else if (we) begin
            code   <= wdata[CODE_W-1:0];
            off    <= wdata[OFF_BIT];
            bypass <= wdata[BYP_BIT];
        end
    end

    always_comb begin
        rdata                = '0;
        rdata[CODE_W-1:0]    = code;
        rdata[OFF_BIT]       = off;
        rdata[BYP_BIT]       = bypass;
    end
endmodule

// File: rtl/clkdiv_fsm.sv
module clkdiv_fsm
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              off,
    output logic              div_hi,
    output logic              pass_sel,
    output logic [CODE_W-1:0] half_q
);
    div_state_e        st_q, st_d;
    logic [CODE_W-1:0] cnt_q, cnt_d, half_d;
    logic              term;

    assign term = (cnt_q == half_q - 1'b1);

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q + 1'b1;
        half_d = half_q;
        unique case (st_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (!off) begin
                    if (code == PASS_CODE) begin
                        st_d = ST_PASS;
                    end else begin
                        st_d   = ST_HIGH;
                        half_d = half_of(code);
                    end
                end
            end
            ST_HIGH: begin
                if (term) begin
                    st_d  = ST_LOW;
                    cnt_d = '0;
                end
            end
            ST_LOW: begin
                if (term) begin
                    cnt_d = '0;
                    if (off) begin
                        st_d = ST_IDLE;
                    end else if (code == PASS_CODE) begin
                        st_d = ST_PASS;
                    end else begin
                        st_d   = ST_HIGH;
                        half_d = half_of(code);
                    end
                end
            end
            ST_PASS: begin
                cnt_d = '0;
                if (off) begin
                    st_d   = ST_HIGH;
                    half_d = CODE_W'(1);
                end else if (code != PASS_CODE) begin
                    st_d   = ST_HIGH;
                    half_d = half_of(code);
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            half_q <= CODE_W'(1);
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            half_q <= half_d;
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_hi   <= 1'b0;
            pass_sel <= 1'b0;
        end else begin
            div_hi   <= (st_d == ST_HIGH) || (st_d == ST_PASS);
            pass_sel <= (st_d == ST_PASS);
        end
    end
endmodule

// File: rtl/host_clock_divider.sv
module host_clock_divider
    import clkdiv_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OFF_BIT     = 3,
    parameter int BYP_BIT     = 7,
    parameter int SYNC_STAGES = 2,
    parameter int STRETCH     = 15
) (
    input  logic              clk_osc,
    input  logic              rst_ext_n,
    input  logic              mode_sel,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              clk_out,
    output logic              cmp_bypass,
    output logic              rst_sync_n
);
    logic [CODE_W-1:0] code;
    logic              off;
    logic              div_hi;
    logic              pass_sel;
    logic [CODE_W-1:0] half_act;

    rst_stretch #(
        .SYNC_STAGES (SYNC_STAGES),
        .STRETCH     (STRETCH)
    ) u_rst (
        .clk     (clk_osc),
        .arst_n  (rst_ext_n),
        .rst_n_o (rst_sync_n)
    );

    clkdiv_cfg #(
        .DATA_W  (DATA_W),
        .OFF_BIT (OFF_BIT),
        .BYP_BIT (BYP_BIT)
    ) u_cfg (
        .clk      (clk_osc),
        .rst_n    (rst_sync_n),
        .mode_sel (mode_sel),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .code     (code),
        .off      (off),
        .bypass   (cmp_bypass)
    );

    clkdiv_fsm u_fsm (
        .clk      (clk_osc),
        .rst_n    (rst_sync_n),
        .code     (code),
        .off      (off),
        .div_hi   (div_hi),
        .pass_sel (pass_sel),
        .half_q   (half_act)
    );

    assign clk_out = pass_sel ? clk_osc : div_hi;
endmodule

// File: rtl/host_clock_divider_chk.sv
module host_clock_divider_chk #(
    parameter int DATA_W  = 8,
    parameter int STRETCH = 15
) (
    input logic              clk_osc,
    input logic              rst_ext_n,
    input logic              rst_sync_n,
    input logic              cfg_we,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              cmp_bypass,
    input logic              div_hi,
    input logic [2:0]        half_act
);
    logic [5:0] low_cnt;

    always_ff @(posedge clk_osc or negedge rst_ext_n) begin
        if (!rst_ext_n)                           low_cnt <= '0;
        else if (!rst_sync_n && low_cnt != 6'h3f) low_cnt <= low_cnt + 1'b1;
    end

    p_cfg_hold_r7: assert property (@(posedge clk_osc) disable iff (!rst_sync_n)
        !cfg_we |=> $stable(cfg_rdata));

    p_bypass_hold_r6: assert property (@(posedge clk_osc) disable iff (!rst_sync_n)
        !cfg_we |=> $stable(cmp_bypass));

    p_off_low_r4: assert property (@(posedge clk_osc) disable iff (!rst_sync_n)
        (cfg_rdata[3] && !div_hi && !cfg_we) |=> !div_hi);

    p_switch_rise_r5: assert property (@(posedge clk_osc) disable iff (!rst_sync_n)
        (half_act != $past(half_act)) |-> div_hi);

    p_stretch_r8: assert property (@(posedge clk_osc) disable iff (!rst_ext_n)
        $rose(rst_sync_n) |-> (low_cnt >= 6'(STRETCH)));

    p_reset_quiet_r9: assert property (@(posedge clk_osc) disable iff (!rst_ext_n)
        !rst_sync_n |=> !div_hi);
endmodule

bind host_clock_divider host_clock_divider_chk #(
    .DATA_W  (DATA_W),
    .STRETCH (STRETCH)
) u_chk (
    .clk_osc    (clk_osc),
    .rst_ext_n  (rst_ext_n),
    .rst_sync_n (rst_sync_n),
    .cfg_we     (cfg_we),
    .cfg_rdata  (cfg_rdata),
    .cmp_bypass (cmp_bypass),
    .div_hi     (div_hi),
    .half_act   (half_act)
);

// File: tb/host_clock_divider_test.sv
`timescale 1ns/1ps
module host_clock_divider_test;
    logic       clk_osc = 1'b0;
    logic       rst_ext_n = 1'b0;
    logic       mode_sel = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       clk_out;
    logic       cmp_bypass;
    logic       rst_sync_n;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  hs [0:127];
    bit  ls [0:127];
    int  runs [$];

    host_clock_divider uut (
        .clk_osc    (clk_osc),
        .rst_ext_n  (rst_ext_n),
        .mode_sel   (mode_sel),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .clk_out    (clk_out),
        .cmp_bypass (cmp_bypass),
        .rst_sync_n (rst_sync_n)
    );

    always #2 clk_osc = ~clk_osc;

    function automatic int exp_half(int code);
        return code + 1;
    endfunction

    function automatic int exp_default(bit mode);
        return mode ? 0 : 5;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk_osc);
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk_osc);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(negedge clk_osc);
        cfg_we    = 1'b0;
    endtask

    task automatic record(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk_osc); #1 hs[i] = clk_out;
            @(negedge clk_osc); #1 ls[i] = clk_out;
        end
    endtask

    // complete runs of equal posedge samples; first and last partial runs dropped
    task automatic build_runs(int n);
        int  len;
        bit  started;
        runs.delete();
        len = 0;
        started = 0;
        for (int i = 1; i < n; i++) begin
            if (hs[i] == hs[i-1]) len++;
            else begin
                if (started) runs.push_back(len);
                started = 1;
                len = 1;
            end
        end
    endtask

    function automatic bit no_pass(int n);
        for (int i = 0; i < n; i++) if (hs[i] != ls[i]) return 0;
        return 1;
    endfunction

    task automatic do_reset(bit mode, string tag);
        bit low_ok;
        @(negedge clk_osc);
        rst_ext_n = 1'b0;
        mode_sel  = mode;
        #1 chk(rst_sync_n == 1'b0, "R8", "async fall", rst_sync_n, 0);
        idle(4);
        @(negedge clk_osc);
        rst_ext_n = 1'b1;
        low_ok = 1;
        for (int i = 0; i < 16; i++) begin
            @(posedge clk_osc); #1;
            if (clk_out !== 1'b0) low_ok = 0;
            if (i == 15) chk(rst_sync_n == 1'b0, "R8", "low after 16 edges", rst_sync_n, 0);
        end
        chk(low_ok, "R9", "clk_out during reset", low_ok, 1);
        chk(cfg_rdata == 8'(exp_default(mode)), "R3", tag, cfg_rdata, exp_default(mode));
        @(posedge clk_osc); #1;
        chk(rst_sync_n == 1'b1, "R8", "high at edge 17", rst_sync_n, 1);
    endtask

    task automatic steady(int code, string req);
        bit ok;
        idle(40);
        record(64);
        build_runs(64);
        ok = no_pass(64) && (runs.size() >= 4);
        foreach (runs[k]) if (runs[k] != exp_half(code)) ok = 0;
        chk(ok, req, "steady half period", runs.size() > 0 ? runs[0] : -1, exp_half(code));
    endtask

    task automatic transition(int oldc, int newc, bit to_off, string req);
        bit ok;
        bit seen_new;
        int ho;
        int hn;
        ho = exp_half(oldc);
        hn = exp_half(newc);
        wr(8'(oldc));
        idle(40 + int'($urandom % 14));
        wr(to_off ? 8'(8'h08 | oldc) : 8'(newc));
        record(96);
        build_runs(96);
        ok = no_pass(96);
        seen_new = 0;
        foreach (runs[k]) begin
            if (to_off) begin
                if (runs[k] != ho) ok = 0;
            end else begin
                if (runs[k] != ho && runs[k] != hn) ok = 0;
                if (seen_new && runs[k] != hn) ok = 0;
                if (hn != ho && runs[k] == hn) seen_new = 1;
            end
        end
        if (to_off) begin
            for (int i = 76; i < 96; i++) if (hs[i] != 1'b0) ok = 0;
        end else begin
            if (runs.size() == 0 || runs[runs.size()-1] != hn) ok = 0;
        end
        chk(ok, req, to_off ? "phases before off" : "phases across change",
            runs.size() > 0 ? runs[runs.size()-1] : -1, to_off ? ho : hn);
    endtask

    initial begin
        int s;
        bit ok;
        s = $urandom(32'd1234);

        do_reset(1'b1, "default, strap high");
        steady(0, "R3");
        do_reset(1'b0, "default, strap low");
        steady(5, "R3");

        // R1: every even code
        for (int c = 0; c < 7; c++) begin
            wr(8'(c));
            steady(c, "R1");
        end

        // R2: pass-through
        wr(8'h07);
        idle(20);
        record(12);
        ok = 1;
        for (int i = 0; i < 12; i++) if (hs[i] != 1'b1 || ls[i] != 1'b0) ok = 0;
        chk(ok, "R2", "forwarded oscillator", ok, 1);
        wr(8'h02);
        steady(2, "R2");

        // R6 / R7: bypass and read-back, ignored bits 6:4
        wr(8'hF3);
        #1 chk(cfg_rdata == 8'h83, "R7", "read-back", cfg_rdata, 8'h83);
        chk(cmp_bypass == 1'b1, "R6", "bypass set", cmp_bypass, 1);
        steady(3, "R7");
        chk(cmp_bypass == 1'b1, "R6", "bypass static", cmp_bypass, 1);
        wr(8'h7B);
        #1 chk(cfg_rdata == 8'h0B, "R7", "read-back off", cfg_rdata, 8'h0B);
        chk(cmp_bypass == 1'b0, "R6", "bypass cleared", cmp_bypass, 0);
        idle(30);
        record(20);
        ok = 1;
        for (int i = 0; i < 20; i++) if (hs[i] || ls[i]) ok = 0;
        chk(ok, "R4", "held low when off", ok, 1);

        // R4: off from pass-through
        wr(8'h07);
        idle(10);
        wr(8'h0F);
        idle(6);
        record(20);
        ok = 1;
        for (int i = 0; i < 20; i++) if (hs[i] || ls[i]) ok = 0;
        chk(ok, "R4", "off after pass-through", ok, 1);

        // R4 directed, R5 directed extremes
        transition(4, 4, 1'b1, "R4");
        transition(6, 0, 1'b0, "R5");
        transition(0, 6, 1'b0, "R5");

        // R5 / R4 random
        for (int it = 0; it < 24; it++) begin
            int oc;
            int nc;
            oc = int'($urandom % 7);
            nc = int'($urandom % 7);
            if ($urandom % 4 == 0) transition(oc, nc, 1'b1, "R4");
            else                   transition(oc, nc, 1'b0, "R5");
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule